// File: doc/BRIEF.md
# Write-Combining Store Buffer

This block gathers stores aimed at uncacheable memory that is marked as combinable. It keeps them in a small pool of line-sized buffers. Each buffer holds a line tag, the line's data bytes and a per-byte valid mask. Stores to the same line fold into one buffer, whether they sit next to each other or overlap, and a later byte always replaces an earlier one. Each buffer later leaves as one merged write on a valid/ready port, carrying the line address, the data and the byte mask.

A buffer leaves for one of three reasons. It has been open for a programmable number of cycles. It is the oldest buffer and a store to a new line needs its slot. Or a drain has been requested. When more than one buffer is due, a rotating pointer picks the next one, so partly filled buffers still drain at similar rates. The drain input is raised for fences, release operations, serializing events and uncached accesses. While it is high, no store is taken. The acknowledge rises only once every buffer is empty and no merged write is still waiting downstream. Stores that are not combinable are refused, and the bypass output says so. A build parameter turns merging off, and then each store leaves as its own write.

Top module: `wcStoreBuffer`

## Requirements
- R1: A store with stCombinable high to a line that no buffer holds is taken (stTaken high) into a free buffer. A store with stCombinable low raises stBypass, is not taken, and never produces a write.
- R2: Stores to the same line, adjacent or overlapping, leave as one write whose wrMask is the OR of their byte enables (bit b of a mask covers data byte b, bits 8b+7..8b).
- R3: Where byte enables overlap, the write carries the byte of the most recent store. Bytes that no store enabled read as zero.
- R4: A store to a new line while all buffers are occupied first sends out the buffer allocated earliest, and is taken afterwards.
- R5: A buffer whose age, counted in cycles since allocation and saturating, reaches ageLimit is sent without any drain request.
- R6: When several buffers are due together, they leave one at a time in rotating order starting after the last one sent, each exactly once.
- R7: While drainReq is high, no store is taken and every buffer is sent. drainAck is high only while drainReq is high, no buffer is occupied and no write is outstanding.
- R8: wrValid, once raised, stays high with a stable address, mask and data until a cycle with wrReady high.
- R9: With COMBINE_EN = 0, two stores to the same line leave as two separate writes, each with only its own byte enables.
- R10: After reset, wrValid, stTaken and drainAck are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| stValid | input | 1 | Store present |
| stLine | input | ADDR_W-log2(LINE_BYTES) | Line address of the store |
| stData | input | LINE_BYTES*8 | Store data, placed at its byte lanes within the line |
| stBe | input | LINE_BYTES | Byte enables of the store |
| stCombinable | input | 1 | Store targets a combinable uncacheable page |
| stTaken | output | 1 | Store accepted this cycle |
| stBypass | output | 1 | Store refused: not combinable |
| drainReq | input | 1 | Ordering event requests a full drain |
| drainAck | output | 1 | All combined data has left |
| ageLimit | input | AGE_W | Age in cycles at which an open buffer is sent |
| wrValid | output | 1 | Merged write present |
| wrReady | input | 1 | Downstream takes the write |
| wrLine | output | ADDR_W-log2(LINE_BYTES) | Line address of the write |
| wrData | output | LINE_BYTES*8 | Merged data |
| wrMask | output | LINE_BYTES | Byte mask of the write |

## Verification
Two things can fall due in the same cycle: a store that wants to merge into a buffer, and that same buffer crossing its age limit. The age launch wins, and the store is held for a cycle and then opens a fresh buffer. The bench provokes this by setting a small age limit and sending a burst of stores to one line, so that aging and merging collide repeatedly. A behavioural model predicts stTaken and every write on each clock, and the bench compares against it. The same comparison covers a store held off by an eviction, and a drain that starts while a write is stalled by wrReady.

// File: rtl/wcb_pkg.sv
package wcb_pkg;
  localparam int IDX_W = 4;

  typedef struct packed {
    logic             launch;
    logic [IDX_W-1:0] launchIdx;
    logic             write;
    logic [IDX_W-1:0] writeIdx;
    logic             alloc;
  } wcbStrobe_t;
endpackage

// File: rtl/wcb_ctrl.sv
module wcb_ctrl #(
  parameter int NUM_BUF    = 4,
  parameter int TAG_W      = 27,
  parameter int AGE_W      = 6,
  parameter int COMBINE_EN = 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   stValid,
  input  logic [TAG_W-1:0]       stLine,
  input  logic                   stCombinable,
  input  logic                   drainReq,
  input  logic [AGE_W-1:0]       ageLimit,
  input  logic                   wrReady,
  output logic                   stTaken,
  output logic                   stBypass,
  output logic                   drainAck,
  output logic                   wrValid,
  output logic [TAG_W-1:0]       wrLine,
  output wcb_pkg::wcbStrobe_t    str
);
  localparam int IW = wcb_pkg::IDX_W;

  logic [NUM_BUF-1:0] valid;
  logic [NUM_BUF-1:0] cand;
  logic [TAG_W-1:0]   tag [NUM_BUF];
  logic [AGE_W-1:0]   age [NUM_BUF];
  logic [IW-1:0]      rrPtr, hitIdx, freeIdx, oldIdx, selIdx, rrNext;
  logic               hit, freeFound, oldFound, selFound;
  logic [AGE_W-1:0]   bestAge;
  logic [TAG_W-1:0]   launchTag;
  logic               isStore, evictNeed, launch;

  // Lookup: hit, first free slot, oldest occupied slot.
  always_comb begin
    hit = 1'b0; hitIdx = '0;
    freeFound = 1'b0; freeIdx = '0;
    oldFound = 1'b0; oldIdx = '0; bestAge = '0;
    for (int i = 0; i < NUM_BUF; i++) begin
      if ((COMBINE_EN != 0) && valid[i] && tag[i] == stLine) begin
        hit = 1'b1;
        hitIdx = IW'(i);
      end
      if (!valid[i] && !freeFound) begin
        freeFound = 1'b1;
        freeIdx = IW'(i);
      end
      if (valid[i] && (!oldFound || age[i] > bestAge)) begin
        oldFound = 1'b1;
        bestAge = age[i];
        oldIdx = IW'(i);
      end
    end
  end

  assign isStore   = stValid && stCombinable;
  assign evictNeed = isStore && !hit && !freeFound && !drainReq;

  // Which buffers are due to be sent.
  always_comb begin
    for (int i = 0; i < NUM_BUF; i++) begin
      cand[i] = valid[i] && (drainReq || (COMBINE_EN == 0) || (age[i] >= ageLimit) ||
                             (evictNeed && oldIdx == IW'(i)));
    end
  end

  // Rotating pick among due buffers.
  always_comb begin
    selFound = 1'b0;
    selIdx = '0;
    for (int k = 0; k < NUM_BUF; k++) begin
      int j;
      j = (int'(rrPtr) + k) % NUM_BUF;
      if (!selFound && cand[j]) begin
        selFound = 1'b1;
        selIdx = IW'(j);
      end
    end
  end

  always_comb begin
    launchTag = '0;
    for (int i = 0; i < NUM_BUF; i++) begin
      if (selIdx == IW'(i)) launchTag = tag[i];
    end
  end

  assign launch   = !wrValid && selFound;
  assign stTaken  = isStore && !drainReq && !launch && (hit || freeFound);
  assign stBypass = stValid && !stCombinable;
  assign drainAck = drainReq && (valid == '0) && !wrValid;
  assign rrNext   = (selIdx == IW'(NUM_BUF - 1)) ? '0 : selIdx + IW'(1);

  always_comb begin
    str.launch    = launch;
    str.launchIdx = selIdx;
    str.write     = stTaken;
    str.writeIdx  = hit ? hitIdx : freeIdx;
    str.alloc     = !hit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      valid   <= '0;
      rrPtr   <= '0;
      wrValid <= 1'b0;
      wrLine  <= '0;
      for (int i = 0; i < NUM_BUF; i++) begin
        tag[i] <= '0;
        age[i] <= '0;
      end
    end else begin
      if (wrValid && wrReady) wrValid <= 1'b0;
      if (launch) begin
        wrValid <= 1'b1;
        wrLine  <= launchTag;
        rrPtr   <= rrNext;
      end
      for (int i = 0; i < NUM_BUF; i++) begin
        if (launch && selIdx == IW'(i)) begin
          valid[i] <= 1'b0;
          age[i]   <= '0;
        end else if (stTaken && !hit && freeIdx == IW'(i)) begin
          valid[i] <= 1'b1;
          tag[i]   <= stLine;
          age[i]   <= '0;
        end else if (valid[i] && age[i] != '1) begin
          age[i] <= age[i] + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/wcb_datapath.sv
module wcb_datapath #(
  parameter int NUM_BUF    = 4,
  parameter int LINE_BYTES = 32
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  wcb_pkg::wcbStrobe_t       str,
  input  logic [LINE_BYTES*8-1:0]   stData,
  input  logic [LINE_BYTES-1:0]     stBe,
  output logic [LINE_BYTES*8-1:0]   wrData,
  output logic [LINE_BYTES-1:0]     wrMask
);
  localparam int IW = wcb_pkg::IDX_W;
  localparam int DW = LINE_BYTES * 8;

  logic [DW-1:0]         dataView [NUM_BUF];
  logic [LINE_BYTES-1:0] maskView [NUM_BUF];
  logic [DW-1:0]         pickData;
  logic [LINE_BYTES-1:0] pickMask;

  for (genvar g = 0; g < NUM_BUF; g++) begin : gBuf
    logic [DW-1:0]         data;
    logic [LINE_BYTES-1:0] mask;
    logic                  sel;

    assign sel = str.write && (str.writeIdx == IW'(g));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        data <= '0;
        mask <= '0;
      end else if (sel) begin
        for (int b = 0; b < LINE_BYTES; b++) begin
          if (stBe[b])        data[b*8 +: 8] <= stData[b*8 +: 8];
          else if (str.alloc) data[b*8 +: 8] <= 8'h00;
        end
        mask <= str.alloc ? stBe : (mask | stBe);
      end
    end

    assign dataView[g] = data;
    assign maskView[g] = mask;
  end

  always_comb begin
    pickData = '0;
    pickMask = '0;
    for (int i = 0; i < NUM_BUF; i++) begin
      if (str.launchIdx == IW'(i)) begin
        pickData = dataView[i];
        pickMask = maskView[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrData <= '0;
      wrMask <= '0;
    end else if (str.launch) begin
      wrData <= pickData;
      wrMask <= pickMask;
    end
  end
endmodule

// File: rtl/wcStoreBuffer.sv
module wcStoreBuffer #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32,
  parameter int NUM_BUF    = 4,
  parameter int AGE_W      = 6,
  parameter int COMBINE_EN = 1
) (
  input  logic                                   clk,
  input  logic                                   rstN,
  input  logic                                   stValid,
  input  logic [ADDR_W-$clog2(LINE_BYTES)-1:0]   stLine,
  input  logic [LINE_BYTES*8-1:0]                stData,
  input  logic [LINE_BYTES-1:0]                  stBe,
  input  logic                                   stCombinable,
  output logic                                   stTaken,
  output logic                                   stBypass,
  input  logic                                   drainReq,
  output logic                                   drainAck,
  input  logic [AGE_W-1:0]                       ageLimit,
  output logic                                   wrValid,
  input  logic                                   wrReady,
  output logic [ADDR_W-$clog2(LINE_BYTES)-1:0]   wrLine,
  output logic [LINE_BYTES*8-1:0]                wrData,
  output logic [LINE_BYTES-1:0]                  wrMask
);
  localparam int OFF_W = $clog2(LINE_BYTES);
  localparam int TAG_W = ADDR_W - OFF_W;

  wcb_pkg::wcbStrobe_t str;

  wcb_ctrl #(
    .NUM_BUF(NUM_BUF), .TAG_W(TAG_W), .AGE_W(AGE_W), .COMBINE_EN(COMBINE_EN)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .stValid(stValid), .stLine(stLine),
    .stCombinable(stCombinable), .drainReq(drainReq), .ageLimit(ageLimit),
    .wrReady(wrReady), .stTaken(stTaken), .stBypass(stBypass),
    .drainAck(drainAck), .wrValid(wrValid), .wrLine(wrLine), .str(str)
  );

  wcb_datapath #(
    .NUM_BUF(NUM_BUF), .LINE_BYTES(LINE_BYTES)
  ) uData (
    .clk(clk), .rstN(rstN), .str(str), .stData(stData), .stBe(stBe),
    .wrData(wrData), .wrMask(wrMask)
  );
endmodule

// File: rtl/wcb_checker.sv
module wcb_checker #(
  parameter int TAG_W      = 27,
  parameter int LINE_BYTES = 32
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  stValid,
  input logic                  stCombinable,
  input logic                  stTaken,
  input logic                  stBypass,
  input logic                  drainReq,
  input logic                  drainAck,
  input logic                  wrValid,
  input logic                  wrReady,
  input logic [TAG_W-1:0]      wrLine,
  input logic [LINE_BYTES-1:0] wrMask
);
  // R1: a refused store is never taken.
  p_bypass_not_taken_r1: assert property (@(posedge clk) disable iff (!rstN)
    stBypass |-> !stTaken);

  // R1: only combinable stores are taken.
  p_taken_combinable_r1: assert property (@(posedge clk) disable iff (!rstN)
    stTaken |-> (stValid && stCombinable));

  // R7: no store enters during a drain.
  p_drain_blocks_store_r7: assert property (@(posedge clk) disable iff (!rstN)
    drainReq |-> !stTaken);

  // R7: acknowledge only with nothing outstanding downstream.
  p_ack_empty_r7: assert property (@(posedge clk) disable iff (!rstN)
    drainAck |-> (!wrValid && drainReq));

  // R8: a stalled write holds its contents.
  p_hold_until_ready_r8: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && !wrReady) |=> (wrValid && $stable(wrLine) && $stable(wrMask)));
endmodule

bind wcStoreBuffer wcb_checker #(.TAG_W(TAG_W), .LINE_BYTES(LINE_BYTES)) uChk (
  .clk(clk), .rstN(rstN), .stValid(stValid), .stCombinable(stCombinable),
  .stTaken(stTaken), .stBypass(stBypass), .drainReq(drainReq),
  .drainAck(drainAck), .wrValid(wrValid), .wrReady(wrReady),
  .wrLine(wrLine), .wrMask(wrMask)
);

// File: tb/wcStoreBuffer_test.sv
module wcStoreBuffer_test;
  localparam int NB = 4;
  localparam int TW = 27;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;

  logic          stValid = 0, stCombinable = 0, drainReq = 0, wrReady = 1;
  logic [TW-1:0] stLine = '0;
  logic [255:0]  stData = '0;
  logic [31:0]   stBe = '0;
  logic [5:0]    ageLimit = 6'd63;
  logic          stTaken, stBypass, drainAck, wrValid;
  logic [TW-1:0] wrLine;
  logic [255:0]  wrData;
  logic [31:0]   wrMask;

  wcStoreBuffer uut (
    .clk(clk), .rstN(rstN), .stValid(stValid), .stLine(stLine), .stData(stData),
    .stBe(stBe), .stCombinable(stCombinable), .stTaken(stTaken), .stBypass(stBypass),
    .drainReq(drainReq), .drainAck(drainAck), .ageLimit(ageLimit), .wrValid(wrValid),
    .wrReady(wrReady), .wrLine(wrLine), .wrData(wrData), .wrMask(wrMask)
  );

  // Second instance with merging disabled.
  logic          pValid = 0;
  logic [TW-1:0] pLine = '0;
  logic [255:0]  pData = '0;
  logic [31:0]   pBe = '0;
  logic          pTaken, pBypass, pAck, pWrValid;
  logic [TW-1:0] pWrLine;
  logic [255:0]  pWrData;
  logic [31:0]   pWrMask;

  wcStoreBuffer #(.COMBINE_EN(0)) uutPass (
    .clk(clk), .rstN(rstN), .stValid(pValid), .stLine(pLine), .stData(pData),
    .stBe(pBe), .stCombinable(1'b1), .stTaken(pTaken), .stBypass(pBypass),
    .drainReq(1'b0), .drainAck(pAck), .ageLimit(6'd63), .wrValid(pWrValid),
    .wrReady(1'b1), .wrLine(pWrLine), .wrData(pWrData), .wrMask(pWrMask)
  );

  int checkCnt = 0;
  int failCnt = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [255:0] act, input logic [255:0] exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  bit            mV [NB];
  logic [TW-1:0] mTag [NB];
  logic [255:0]  mD [NB];
  logic [31:0]   mM [NB];
  int            mAge [NB];
  int            mRr = 0;
  bit            oV = 0;
  logic [TW-1:0] oTag = '0;
  logic [255:0]  oD = '0;
  logic [31:0]   oM = '0;

  bit sLaunch, sTaken, sReady;
  int sSel, sHit, sFree;
  logic [TW-1:0] sLine;
  logic [255:0]  sData;
  logic [31:0]   sBe;

  // Accepted writes of the main instance.
  logic [TW-1:0] logLine [64];
  logic [31:0]   logMask [64];
  logic [255:0]  logData [64];
  int logN = 0;
  logic [31:0]   pMaskLog [8];
  logic [TW-1:0] pLineLog [8];
  int pN = 0;

  always @(negedge clk) begin
    if (rstN) begin
      bit isSt, full, ev, eTaken, eBypass, eAck, anyV;
      int hit, free, old, sel;
      isSt = stValid && stCombinable;
      hit = -1; free = -1; old = -1; anyV = 0;
      for (int i = 0; i < NB; i++) begin
        if (mV[i] && mTag[i] == stLine) hit = i;
        if (!mV[i] && free < 0) free = i;
        if (mV[i] && (old < 0 || mAge[i] > mAge[old])) old = i;
        if (mV[i]) anyV = 1;
      end
      full = (free < 0);
      ev = isSt && hit < 0 && full && !drainReq;
      sel = -1;
      for (int k = 0; k < NB; k++) begin
        int j;
        j = (mRr + k) % NB;
        if (sel < 0 && mV[j] && (drainReq || mAge[j] >= int'(ageLimit) || (ev && j == old)))
          sel = j;
      end
      sLaunch = !oV && sel >= 0;
      eTaken = isSt && !drainReq && !sLaunch && (hit >= 0 || !full);
      eBypass = stValid && !stCombinable;
      eAck = drainReq && !anyV && !oV;
      chk(stTaken == eTaken, "R1", "stTaken", 256'(stTaken), 256'(eTaken));
      chk(stBypass == eBypass, "R1", "stBypass", 256'(stBypass), 256'(eBypass));
      chk(drainAck == eAck, "R7", "drainAck", 256'(drainAck), 256'(eAck));
      chk(wrValid == oV, "R8", "wrValid", 256'(wrValid), 256'(oV));
      if (oV) begin
        chk(wrLine == oTag, "R6", "wrLine", 256'(wrLine), 256'(oTag));
        chk(wrMask == oM, "R2", "wrMask", 256'(wrMask), 256'(oM));
        chk(wrData == oD, "R3", "wrData", wrData, oD);
      end
      if (wrValid && wrReady && logN < 64) begin
        logLine[logN] = wrLine; logMask[logN] = wrMask; logData[logN] = wrData;
        logN++;
      end
      if (pWrValid && pN < 8) begin
        pMaskLog[pN] = pWrMask; pLineLog[pN] = pWrLine;
        pN++;
      end
      sTaken = eTaken; sSel = sel; sHit = hit; sFree = free;
      sReady = wrReady; sLine = stLine; sData = stData; sBe = stBe;
    end
  end

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NB; i++) begin
        mV[i] = 0; mTag[i] = '0; mD[i] = '0; mM[i] = '0; mAge[i] = 0;
      end
      mRr = 0; oV = 0;
      sLaunch = 0; sTaken = 0;
    end else begin
      if (oV && sReady) oV = 0;
      if (sLaunch) begin
        oV = 1; oTag = mTag[sSel]; oD = mD[sSel]; oM = mM[sSel];
        mRr = (sSel + 1) % NB;
      end
      if (sTaken && sHit >= 0) begin
        for (int b = 0; b < 32; b++)
          if (sBe[b]) mD[sHit][b*8 +: 8] = sData[b*8 +: 8];
        mM[sHit] = mM[sHit] | sBe;
      end
      for (int i = 0; i < NB; i++) begin
        if (sLaunch && i == sSel) begin
          mV[i] = 0; mAge[i] = 0;
        end else if (sTaken && sHit < 0 && i == sFree) begin
          mV[i] = 1; mTag[i] = sLine; mAge[i] = 0; mM[i] = sBe;
          for (int b = 0; b < 32; b++)
            mD[i][b*8 +: 8] = sBe[b] ? sData[b*8 +: 8] : 8'h00;
        end else if (mV[i] && mAge[i] < 63) begin
          mAge[i] = mAge[i] + 1;
        end
      end
      sLaunch = 0; sTaken = 0;
    end
  end

  // ---------------- stimulus helpers ----------------
  function automatic logic [255:0] pat(input logic [7:0] base);
    logic [255:0] r;
    for (int b = 0; b < 32; b++) r[b*8 +: 8] = base + 8'(b);
    return r;
  endfunction

  task automatic doStore(input logic [TW-1:0] line, input logic [31:0] be,
                         input logic [255:0] d, input bit comb, output bit wasBypass);
    @(posedge clk); #1;
    stValid = 1; stLine = line; stBe = be; stData = d; stCombinable = comb;
    wasBypass = 0;
    for (int n = 0; n < 300; n++) begin
      @(negedge clk);
      if (stTaken) break;
      if (stBypass) begin wasBypass = 1; break; end
    end
    @(posedge clk); #1;
    stValid = 0;
  endtask

  task automatic doDrain();
    @(posedge clk); #1;
    drainReq = 1;
    for (int n = 0; n < 300; n++) begin
      @(negedge clk);
      if (drainAck) break;
    end
    @(posedge clk); #1;
    drainReq = 0;
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checkCnt++; failCnt++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
      $finish;
    end
  end

  // ---------------- main sequence ----------------
  initial begin
    bit byp;
    int base;
    repeat (4) @(posedge clk);
    #1 rstN = 1;
    @(negedge clk);
    chk(!wrValid && !stTaken && !drainAck, "R10", "reset state",
        256'({wrValid, stTaken, drainAck}), 256'(0));

    // Adjacent stores merge (R2).
    base = logN;
    doStore(27'h100, 32'h0000_0030, pat(8'h10), 1, byp);
    doStore(27'h100, 32'h0000_00C0, pat(8'h80), 1, byp);
    doDrain();
    chk(logN == base + 1, "R2", "adjacent write count", 256'(logN - base), 256'(1));
    chk(logMask[base] == 32'h0000_00F0, "R2", "adjacent mask", 256'(logMask[base]), 256'h0F0);

    // Overlapping stores, newest byte wins (R3).
    base = logN;
    doStore(27'h101, 32'h0000_0060, pat(8'h10), 1, byp);
    doStore(27'h101, 32'h0000_00C0, pat(8'h80), 1, byp);
    doDrain();
    chk(logMask[base] == 32'h0000_00E0, "R2", "overlap mask", 256'(logMask[base]), 256'h0E0);
    chk(logData[base][63:40] == 24'h878615, "R3", "overlap bytes",
        256'(logData[base][63:40]), 256'h878615);
    chk(logData[base][39:0] == 40'h0, "R3", "unwritten bytes zero",
        256'(logData[base][39:0]), 256'h0);

    // Non-combinable store is refused (R1).
    base = logN;
    doStore(27'h102, 32'h0000_000F, pat(8'h20), 0, byp);
    chk(byp, "R1", "bypass raised", 256'(byp), 256'(1));
    doDrain();
    chk(logN == base, "R1", "refused store wrote nothing", 256'(logN - base), 256'(0));

    // Eviction of the oldest buffer (R4).
    base = logN;
    for (int i = 0; i < 4; i++) doStore(27'h110 + 27'(i), 32'h1, pat(8'h30), 1, byp);
    doStore(27'h114, 32'h2, pat(8'h40), 1, byp);
    chk(logN == base + 1, "R4", "one eviction", 256'(logN - base), 256'(1));
    chk(logLine[base] == 27'h110, "R4", "evicted line", 256'(logLine[base]), 256'h110);
    doDrain();
    chk(logN == base + 5, "R4", "writes after drain", 256'(logN - base), 256'(5));

    // Age-limit flush without drain (R5).
    base = logN;
    ageLimit = 6'd8;
    doStore(27'h120, 32'h4, pat(8'h50), 1, byp);
    repeat (20) @(posedge clk);
    chk(logN == base + 1 && logLine[base] == 27'h120, "R5", "aged flush line",
        256'(logLine[base]), 256'h120);

    // Aging collides with merging stores (R5).
    ageLimit = 6'd3;
    base = logN;
    for (int i = 0; i < 8; i++) doStore(27'h121, 32'(1) << i, pat(8'h60), 1, byp);
    repeat (10) @(posedge clk);
    chk(logN > base + 1, "R5", "collision produced several writes", 256'(logN - base), 256'(2));
    ageLimit = 6'd63;

    // Drain with stalled downstream, rotation fairness (R6, R7, R8).
    wrReady = 0;
    for (int i = 0; i < 4; i++) doStore(27'h130 + 27'(i), 32'h8, pat(8'h70), 1, byp);
    base = logN;
    @(posedge clk); #1;
    drainReq = 1;
    stValid = 1; stCombinable = 1; stLine = 27'h134; stBe = 32'h1;
    @(negedge clk);
    chk(!stTaken, "R7", "store held during drain", 256'(stTaken), 256'(0));
    @(posedge clk); #1;
    stValid = 0;
    @(negedge clk);
    begin
      logic [TW-1:0] held;
      held = wrLine;
      repeat (4) @(negedge clk);
      chk(wrValid && wrLine == held, "R8", "stalled write held", 256'(wrLine), 256'(held));
      chk(!drainAck, "R7", "no ack while write outstanding", 256'(drainAck), 256'(0));
    end
    @(posedge clk); #1;
    wrReady = 1;
    for (int n = 0; n < 300; n++) begin
      @(negedge clk);
      if (drainAck) break;
    end
    @(posedge clk); #1;
    drainReq = 0;
    chk(logN == base + 4, "R6", "four drained writes", 256'(logN - base), 256'(4));
    for (int i = 0; i < 4; i++) begin
      int seen;
      seen = 0;
      for (int e = base; e < base + 4; e++)
        if (logLine[e] == 27'h130 + 27'(i)) seen++;
      chk(seen == 1, "R6", "each line sent once", 256'(seen), 256'(1));
    end

    // Merging disabled instance (R9).
    @(posedge clk); #1;
    pValid = 1; pLine = 27'h140; pBe = 32'h3; pData = pat(8'h90);
    for (int n = 0; n < 50; n++) begin @(negedge clk); if (pTaken) break; end
    @(posedge clk); #1;
    pBe = 32'hC;
    for (int n = 0; n < 50; n++) begin @(negedge clk); if (pTaken) break; end
    @(posedge clk); #1;
    pValid = 0;
    repeat (10) @(posedge clk);
    chk(pN == 2, "R9", "separate writes", 256'(pN), 256'(2));
    chk(pMaskLog[0] == 32'h3 && pLineLog[0] == 27'h140, "R9", "first mask",
        256'(pMaskLog[0]), 256'h3);
    chk(pMaskLog[1] == 32'hC && pLineLog[1] == 27'h140, "R9", "second mask",
        256'(pMaskLog[1]), 256'hC);

    repeat (4) @(posedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end
endmodule